// File: doc/BRIEF.md
# Single-Pole Recursive Low-Pass Smoother

This block smooths a stream of signed two's-complement audio samples with a one-pole recursive low-pass filter, y[n] = (1-a)*x[n] + a*y[n-1]. The feedback weight a and its complement (1-a) are fixed at elaboration time. Each is given as an integer equal to the real value times 1024 and rounded, so a = 0.25 becomes 256 and 768, and a = 0.7 becomes 717. Both constants are held as signed 11-bit values with a guard sign bit, so a magnitude of 512 or more is never read as negative.

A sample is presented with a valid strobe and is first captured in an input register. On the next clock the two products are summed at full width. The sum is optionally rounded, shifted right by the ten fraction bits and clipped to the sample range. The result is then written to the single state register. That register is both the filter output and the y[n-1] term fed back, so the recursion loop holds exactly one register and the feedback is kept at sample width.

Top module: `iir_lowpass1`

## Requirements
- R1: While rst_n is low, out_sample is 0 and out_valid is 0.
- R2: A sample accepted with in_valid high at clock edge k produces out_valid high for exactly the one cycle after edge k+1. out_valid is low in every other cycle.
- R3: With rounding on (ROUND_EN=1), each output is sat(floor((COEF_B*x + COEF_A*yprev + 512) / 1024)). The division is an arithmetic right shift by 10 on the exact integer sum.
- R4: With rounding off (ROUND_EN=0), each output is sat(floor((COEF_B*x + COEF_A*yprev) / 1024)). No offset is added before the shift.
- R5: sat() clips any result above 2^(SAMPLE_W-1)-1 to that value and any result below -2^(SAMPLE_W-1) to that value. With the defaults the limits are 127 and -128.
- R6: yprev is the previous out_sample value at sample width, or 0 after reset. The wide sum is never fed back.
- R7: In a cycle that follows an edge with no accepted sample, out_sample keeps its value and out_valid is low.
- R8: Coefficients from 0 to 1023 act as non-negative weights. For example, 900 and 900 give a gain above one that saturates, and full-scale inputs under unity-gain coefficients give exact, unwrapped results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| in_valid | input | 1 | High when in_sample carries a new sample |
| in_sample | input | SAMPLE_W | Signed two's-complement input sample |
| out_sample | output | SAMPLE_W | Signed filtered sample, which is also the filter state |
| out_valid | output | 1 | One-cycle strobe marking a newly computed out_sample |

## Verification
A sample driven before edge k is captured at edge k, and its filtered value with out_valid appears after edge k+1, so every result is due two rising edges after it is presented. The bench drives on falling edges and keeps a two-deep pipeline of expected valid flags and expected state values. At each falling edge it compares the entry launched two falling edges earlier, which also checks that outputs hold during idle cycles. Three instances with different coefficients and rounding modes see the same stimulus: a full ramp over every input code, a scrambled sweep, long full-scale runs and a gapped-valid pattern.

// File: rtl/iir_lp_pkg.sv
package iir_lp_pkg;
  // Guard sign bit placed above the coefficient magnitude.
  localparam int COEF_GUARD = 1;
  // Headroom bits above the product width.
  localparam int SUM_HEADROOM = 2;

  function automatic int coef_width(input int frac_bits);
    return frac_bits + COEF_GUARD;
  endfunction

  function automatic int acc_width(input int sample_w, input int frac_bits);
    return sample_w + coef_width(frac_bits) + SUM_HEADROOM;
  endfunction
endpackage

// File: rtl/iir_input_stage.sv
module iir_input_stage #(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic signed [SAMPLE_W-1:0] x_q,
  output logic                       x_valid_q
);
  logic signed [SAMPLE_W-1:0] x_d;
  logic                       x_valid_d;

  always_comb begin
    x_d       = x_q;
    x_valid_d = in_valid;
    if (in_valid) x_d = in_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q       <= '0;
      x_valid_q <= 1'b0;
    end else begin
      x_q       <= x_d;
      x_valid_q <= x_valid_d;
    end
  end
endmodule

// File: rtl/iir_mac.sv
module iir_mac #(
  parameter int SAMPLE_W  = 8,
  parameter int FRAC_BITS = 10,
  parameter int COEF_A    = 256,
  parameter int COEF_B    = 768,
  parameter int ACC_W     = iir_lp_pkg::acc_width(SAMPLE_W, FRAC_BITS)
) (
  input  logic signed [SAMPLE_W-1:0] x,
  input  logic signed [SAMPLE_W-1:0] y_prev,
  output logic signed [ACC_W-1:0]    acc
);
  localparam int COEF_W = iir_lp_pkg::coef_width(FRAC_BITS);
  localparam logic signed [COEF_W-1:0] A_Q = COEF_W'(COEF_A);
  localparam logic signed [COEF_W-1:0] B_Q = COEF_W'(COEF_B);

  logic signed [ACC_W-1:0] x_ext, y_ext, a_ext, b_ext;
  logic signed [ACC_W-1:0] prod_x, prod_y;

  always_comb begin
    x_ext  = ACC_W'(x);
    y_ext  = ACC_W'(y_prev);
    a_ext  = ACC_W'(A_Q);
    b_ext  = ACC_W'(B_Q);
    prod_x = x_ext * b_ext;
    prod_y = y_ext * a_ext;
    acc    = prod_x + prod_y;
  end
endmodule

// File: rtl/iir_requant.sv
module iir_requant #(
  parameter int SAMPLE_W  = 8,
  parameter int FRAC_BITS = 10,
  parameter bit ROUND_EN  = 1'b1,
  parameter int ACC_W     = iir_lp_pkg::acc_width(SAMPLE_W, FRAC_BITS)
) (
  input  logic signed [ACC_W-1:0]    acc,
  output logic signed [SAMPLE_W-1:0] y_sat
);
  localparam logic signed [ACC_W-1:0] ONE   = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MAX_W = (ONE <<< (SAMPLE_W-1)) - ONE;
  localparam logic signed [ACC_W-1:0] MIN_W = -(ONE <<< (SAMPLE_W-1));

  logic signed [ACC_W-1:0] biased;
  logic signed [ACC_W-1:0] shifted;

  generate
    if (ROUND_EN) begin : g_round
      localparam logic signed [ACC_W-1:0] HALF = ONE <<< (FRAC_BITS-1);
      assign biased = acc + HALF;
    end else begin : g_trunc
      assign biased = acc;
    end
  endgenerate

  always_comb begin
    shifted = biased >>> FRAC_BITS;
    if (shifted > MAX_W)      y_sat = SAMPLE_W'(MAX_W);
    else if (shifted < MIN_W) y_sat = SAMPLE_W'(MIN_W);
    else                      y_sat = shifted[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/iir_lowpass1.sv
module iir_lowpass1 #(
  parameter int SAMPLE_W  = 8,
  parameter int FRAC_BITS = 10,
  parameter int COEF_A    = 256,
  parameter int COEF_B    = 768,
  parameter bit ROUND_EN  = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic signed [SAMPLE_W-1:0] out_sample,
  output logic                       out_valid
);
  localparam int ACC_W = iir_lp_pkg::acc_width(SAMPLE_W, FRAC_BITS);

  logic signed [SAMPLE_W-1:0] x_q;
  logic                       x_valid_q;
  logic signed [ACC_W-1:0]    acc;
  logic signed [SAMPLE_W-1:0] y_new;
  logic signed [SAMPLE_W-1:0] y_q, y_d;
  logic                       ov_q, ov_d;

  iir_input_stage #(.SAMPLE_W(SAMPLE_W)) u_in (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .x_q(x_q), .x_valid_q(x_valid_q)
  );

  iir_mac #(
    .SAMPLE_W(SAMPLE_W), .FRAC_BITS(FRAC_BITS),
    .COEF_A(COEF_A), .COEF_B(COEF_B), .ACC_W(ACC_W)
  ) u_mac (
    .x(x_q), .y_prev(y_q), .acc(acc)
  );

  iir_requant #(
    .SAMPLE_W(SAMPLE_W), .FRAC_BITS(FRAC_BITS),
    .ROUND_EN(ROUND_EN), .ACC_W(ACC_W)
  ) u_rq (
    .acc(acc), .y_sat(y_new)
  );

  // The state register is the only storage inside the recursion.
  always_comb begin
    y_d  = y_q;
    ov_d = x_valid_q;
    if (x_valid_q) y_d = y_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q  <= '0;
      ov_q <= 1'b0;
    end else begin
      y_q  <= y_d;
      ov_q <= ov_d;
    end
  end

  assign out_sample = y_q;
  assign out_valid  = ov_q;
endmodule

// File: rtl/iir_lowpass1_chk.sv
module iir_lowpass1_chk #(
  parameter int SAMPLE_W  = 8,
  parameter int FRAC_BITS = 10,
  parameter int COEF_A    = 256,
  parameter int COEF_B    = 768,
  parameter bit ROUND_EN  = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic signed [SAMPLE_W-1:0] x_q,
  input logic                       x_valid_q,
  input logic signed [SAMPLE_W-1:0] out_sample,
  input logic                       out_valid
);
  function automatic logic signed [SAMPLE_W-1:0] ref_step(
    input logic signed [SAMPLE_W-1:0] xv,
    input logic signed [SAMPLE_W-1:0] yv
  );
    longint s, hi, lo;
    s  = longint'(COEF_B) * longint'(xv) + longint'(COEF_A) * longint'(yv);
    if (ROUND_EN) s = s + (longint'(1) <<< (FRAC_BITS-1));
    s  = s >>> FRAC_BITS;
    hi = (longint'(1) <<< (SAMPLE_W-1)) - 1;
    lo = -(longint'(1) <<< (SAMPLE_W-1));
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return SAMPLE_W'(s);
  endfunction

  // R2: an accepted input yields a strobe one edge later
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    x_valid_q |=> out_valid);

  // R2: no strobe without an accepted input
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !x_valid_q |=> !out_valid);

  // R7: idle cycles leave the state unchanged
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !x_valid_q |=> $stable(out_sample));

  // R3 R4 R5 R6: state update follows the recurrence on the narrow feedback
  assert_recurrence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    x_valid_q |=> out_sample == ref_step($past(x_q), $past(out_sample)));
endmodule

bind iir_lowpass1 iir_lowpass1_chk #(
  .SAMPLE_W(SAMPLE_W), .FRAC_BITS(FRAC_BITS),
  .COEF_A(COEF_A), .COEF_B(COEF_B), .ROUND_EN(ROUND_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .x_q(x_q), .x_valid_q(x_valid_q),
  .out_sample(out_sample), .out_valid(out_valid)
);

// File: tb/iir_lowpass1_bench.sv
`timescale 1ns/1ps
module iir_lowpass1_bench;
  localparam int CLK_NS = 20;
  localparam int N_STIM = 900;
  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [7:0] in_sample = '0;
  logic signed [7:0] o_s [NI];
  logic              o_v [NI];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // per instance: coefficient a, complement, rounding
  int  ca [NI] = '{256, 717, 900};
  int  cb [NI] = '{768, 307, 900};
  bit  rn [NI] = '{1'b1, 1'b0, 1'b1};

  always #(CLK_NS/2) clk = ~clk;

  iir_lowpass1 u_iir_lowpass1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_sample(o_s[0]), .out_valid(o_v[0]));

  iir_lowpass1 #(.COEF_A(717), .COEF_B(307), .ROUND_EN(1'b0)) u_iir_lowpass1_trunc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_sample(o_s[1]), .out_valid(o_v[1]));

  iir_lowpass1 #(.COEF_A(900), .COEF_B(900), .ROUND_EN(1'b1)) u_iir_lowpass1_hot (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_sample(o_s[2]), .out_valid(o_v[2]));

  function automatic int model(int x, int y, int a, int b, bit r);
    int s;
    s = b * x + a * y + (r ? 512 : 0);
    s = s >>> 10;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus table computed per step
  task automatic stim(int i, output bit v, output int x);
    if (i < 256)      begin v = 1; x = i - 128; end
    else if (i < 512) begin v = 1; x = ((i * 37 + 11) & 255) - 128; end
    else if (i < 560) begin v = 1; x = 127; end
    else if (i < 610) begin v = 1; x = -128; end
    else if (i < N_STIM) begin
      v = (i % 3 != 0) && (i % 7 != 0);
      x = ((i * 91 + 5) & 255) - 128;
    end else begin v = 0; x = 0; end
  endtask

  int  st [NI];
  bit  pv0, pv1;
  int  pe0 [NI];
  int  pe1 [NI];

  initial begin
    for (int k = 0; k < NI; k++) begin st[k] = 0; pe0[k] = 0; pe1[k] = 0; end
    pv0 = 0; pv1 = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      check("R1 out_sample in reset", int'(o_s[k]), 0);
      check("R1 out_valid in reset", int'(o_v[k]), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < N_STIM + 3; i++) begin
      bit v; int x;
      @(negedge clk);
      for (int k = 0; k < NI; k++) begin
        check("R2 out_valid timing", int'(o_v[k]), int'(pv1));
        if (!pv1)
          check("R7 hold when idle", int'(o_s[k]), pe1[k]);
        else if (k == 0)
          check("R3 R6 rounded recurrence", int'(o_s[k]), pe1[k]);
        else if (k == 1)
          check("R4 truncated recurrence", int'(o_s[k]), pe1[k]);
        else
          check("R5 R8 saturating gain above one", int'(o_s[k]), pe1[k]);
      end
      pv1 = pv0;
      for (int k = 0; k < NI; k++) pe1[k] = pe0[k];
      stim(i, v, x);
      in_valid  = v;
      in_sample = 8'(x);
      if (v)
        for (int k = 0; k < NI; k++) st[k] = model(x, st[k], ca[k], cb[k], rn[k]);
      pv0 = v;
      for (int k = 0; k < NI; k++) pe0[k] = st[k];
    end
    // R1: reset again mid-stream clears state
    in_valid = 1'b1; in_sample = 8'sd100;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      check("R1 out_sample after reset", int'(o_s[k]), 0);
      check("R1 out_valid after reset", int'(o_v[k]), 0);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule